// File: doc/BRIEF.md
# I2C Target Byte Transfer Engine

This block is the target (slave) side of a two-wire serial bus. It oversamples the clock line and the data line with a fast system clock and finds the bus conditions in those samples: START, repeated START and STOP. After a START it shifts in a 7-bit calling address and a direction bit. It compares the address with a programmable own address and acknowledges only when the two are equal. Data bytes then flow in the direction that the master asked for, with an acknowledge slot after every byte. The data line is open-drain: the block drives it only low, through an output enable.

Received bytes leave on `rx_data` with a one-cycle `rx_valid` strobe. The bus cannot be stalled, because clock stretching is not supported, so `rx_ready` is a level. The block samples it when the last bit of a byte arrives. High means the byte is strobed out and acknowledged. Low means the byte is dropped and refused with a NACK.

Bytes to transmit enter through a valid/ready stream. While a read is active and the one-byte holding slot is empty, `tx_ready` is high. A byte moves when `tx_valid` and `tx_ready` are both high on a clock edge. The held byte goes onto the bus at the SCL falling edge that starts the next byte. If the slot is still empty at that edge, 0xFF is sent. A START or a STOP flushes the slot.

Top module: `i2c_target_engine`

## Requirements
- R1: After a START, the block shifts in 8 bits on SCL rising edges: the address MSB first, then the direction bit. When the 7 address bits equal `own_addr`, it drives SDA low during the 9th SCL pulse. `dir_read` then takes the direction bit, where 1 means the target sends and 0 means the master writes.
- R2: When the address does not match, the block never drives SDA and produces no `rx_valid` until the next START. `addressed` stays 0.
- R3: In a write transfer, each data byte is sampled MSB first on SCL rising edges. If `rx_ready` is high at the 8th bit, the byte appears on `rx_data` with a single-cycle `rx_valid` pulse, and SDA is driven low during the 9th pulse.
- R4: If `rx_ready` is low at the 8th bit of a write byte, the block gives no strobe and leaves SDA released in the 9th pulse (NACK).
- R5: The driven SDA value changes only while SCL is low. It is updated after SCL falling edges, never while SCL is high.
- R6: In a read transfer, each byte is sent MSB first. It is the byte last accepted through the `tx_valid`/`tx_ready` handshake, or 0xFF if no byte was accepted before the byte started.
- R7: If the master NACKs a transmitted byte (SDA high in the 9th pulse), SDA stays released and `tx_ready` drops. No further byte is sent until a new START.
- R8: A START or repeated START sets `bus_busy`, clears `addressed` and restarts address reception.
- R9: A STOP (SDA rising while SCL is high), including one right after an ACK, clears `bus_busy` and `addressed` and releases SDA. The next START is matched normally.
- R10: `addressed` rises at the SCL falling edge that begins the ACK of a matching address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr | input | 7 | Address this target answers to |
| scl_in | input | 1 | Sampled bus clock line |
| sda_in | input | 1 | Sampled bus data line |
| sda_oe | output | 1 | When high, pull SDA low |
| rx_data | output | 8 | Last byte received from the master |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| rx_ready | input | 1 | User can take the byte being received (ACK/NACK choice) |
| tx_data | input | 8 | Byte offered for transmission |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Holding slot empty during a read transfer |
| addressed | output | 1 | Own address was acknowledged in this transfer |
| dir_read | output | 1 | Direction of the current transfer, 1 = target sends |
| bus_busy | output | 1 | Between a START and a STOP |

## Verification
The assertions assume that SCL stays low for well over the synchronizer depth plus two clocks after each falling edge. They also assume the master changes SDA only while SCL is low, except when it forms START and STOP. Under those conditions the target's drive changes fall where SCL is low. The bench master holds every SCL phase for 20 system clocks. It changes SDA a few clocks after SCL falls, and it sets up START/STOP only while the target has released the line. The stimulus therefore never creates false conditions and never meets a contended SDA.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RX,
    ST_ACK_PEND,
    ST_ACK_SLOT,
    ST_TX,
    ST_TX_ACK,
    ST_TX_LOAD
  } tgt_state_e;
endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_in};
      sda_q <= {sda_q[STAGES-2:0], sda_in};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_tx_feeder.sv
module i2c_tx_feeder #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              want,
  input  logic              take,
  input  logic              flush,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] next_byte
);
  logic              full;
  logic [DATA_W-1:0] hold;

  assign tx_ready  = want & ~full;
  assign next_byte = full ? hold : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      hold <= '0;
    end else if (flush) begin
      full <= 1'b0;
    end else if (tx_valid && tx_ready) begin
      hold <= tx_data;
      full <= 1'b1;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              rx_ready,
  input  logic [DATA_W-1:0] next_byte,
  output logic              sda_oe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              addressed,
  output logic              dir_read,
  output logic              busy,
  output logic              want_tx,
  output logic              take_tx
);
  localparam int SH_W  = (ADDR_W + 1 > DATA_W) ? ADDR_W + 1 : DATA_W;
  localparam int CNT_W = $clog2(SH_W + 1);

  tgt_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [SH_W-2:0]   sh;
  logic [DATA_W-2:0] tx_sh;
  logic              ack_bit;
  logic              addr_phase;

  assign want_tx = addressed & dir_read &
                   (state != ST_IDLE) & (state != ST_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      sh         <= '0;
      tx_sh      <= '1;
      ack_bit    <= 1'b0;
      addr_phase <= 1'b0;
      sda_oe     <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      addressed  <= 1'b0;
      dir_read   <= 1'b0;
      busy       <= 1'b0;
      take_tx    <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      take_tx  <= 1'b0;
      if (start_evt) begin
        state     <= ST_ADDR;
        cnt       <= '0;
        sda_oe    <= 1'b0;
        addressed <= 1'b0;
        busy      <= 1'b1;
      end else if (stop_evt) begin
        state     <= ST_IDLE;
        sda_oe    <= 1'b0;
        addressed <= 1'b0;
        busy      <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: if (scl_rise) begin
            sh <= {sh[SH_W-3:0], sda_s};
            if (cnt == CNT_W'(ADDR_W)) begin
              if (sh[ADDR_W-1:0] == own_addr) begin
                dir_read   <= sda_s;
                ack_bit    <= 1'b1;
                addr_phase <= 1'b1;
                state      <= ST_ACK_PEND;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_RX: if (scl_rise) begin
            sh <= {sh[SH_W-3:0], sda_s};
            if (cnt == CNT_W'(DATA_W - 1)) begin
              rx_data    <= {sh[DATA_W-2:0], sda_s};
              rx_valid   <= rx_ready;
              ack_bit    <= rx_ready;
              addr_phase <= 1'b0;
              state      <= ST_ACK_PEND;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_ACK_PEND: if (scl_fall) begin
            sda_oe <= ack_bit;
            if (addr_phase) addressed <= 1'b1;
            state <= ST_ACK_SLOT;
          end
          ST_ACK_SLOT: if (scl_fall) begin
            cnt <= '0;
            if (addr_phase && dir_read) begin
              sda_oe  <= ~next_byte[DATA_W-1];
              tx_sh   <= next_byte[DATA_W-2:0];
              take_tx <= 1'b1;
              state   <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_RX;
            end
          end
          ST_TX: if (scl_fall) begin
            if (cnt == CNT_W'(DATA_W - 1)) begin
              sda_oe <= 1'b0;
              state  <= ST_TX_ACK;
            end else begin
              sda_oe <= ~tx_sh[DATA_W-2];
              tx_sh  <= {tx_sh[DATA_W-3:0], 1'b1};
              cnt    <= cnt + 1'b1;
            end
          end
          ST_TX_ACK: if (scl_rise) begin
            state <= sda_s ? ST_IDLE : ST_TX_LOAD;
          end
          ST_TX_LOAD: if (scl_fall) begin
            sda_oe  <= ~next_byte[DATA_W-1];
            tx_sh   <= next_byte[DATA_W-2:0];
            take_tx <= 1'b1;
            cnt     <= '0;
            state   <= ST_TX;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_target_engine.sv
module i2c_target_engine #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              addressed,
  output logic              dir_read,
  output logic              bus_busy
);
  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic want_tx, take_tx;
  logic [DATA_W-1:0] next_byte;

  i2c_bus_sampler #(.STAGES(SYNC_STAGES)) i_sampler (
    .clk, .rst_n, .scl_in, .sda_in,
    .sda_s, .scl_rise, .scl_fall, .start_evt, .stop_evt
  );

  i2c_tx_feeder #(.DATA_W(DATA_W)) i_feeder (
    .clk, .rst_n,
    .want      (want_tx),
    .take      (take_tx),
    .flush     (start_evt | stop_evt),
    .tx_data, .tx_valid, .tx_ready,
    .next_byte (next_byte)
  );

  i2c_tgt_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fsm (
    .clk, .rst_n, .own_addr, .sda_s, .scl_rise, .scl_fall,
    .start_evt, .stop_evt, .rx_ready, .next_byte,
    .sda_oe, .rx_data, .rx_valid, .addressed, .dir_read,
    .busy      (bus_busy),
    .want_tx, .take_tx
  );
endmodule

// File: rtl/i2c_target_checker.sv
module i2c_target_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic sda_oe,
  input logic rx_valid,
  input logic tx_ready,
  input logic addressed,
  input logic dir_read,
  input logic bus_busy,
  input logic start_evt,
  input logic stop_evt
);
  // R2: only an acknowledged target ever pulls the data line
  a_r2_silent_unaddressed: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> addressed);

  // R5: drive changes only while SCL is low
  a_r5_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_in);

  // R3: receive strobe is one cycle long and belongs to a write transfer
  a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r3_strobe_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (addressed && !dir_read));

  // R7: no transmit request without an acknowledged read
  a_r7_ready_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (addressed && dir_read));

  // R8: start sets busy and drops the addressed flag
  a_r8_start_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (bus_busy && !addressed));

  // R9: stop frees the bus and the line
  a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!bus_busy && !addressed && !sda_oe));
endmodule

bind i2c_target_engine i2c_target_checker u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_in    (scl_in),
  .sda_oe    (sda_oe),
  .rx_valid  (rx_valid),
  .tx_ready  (tx_ready),
  .addressed (addressed),
  .dir_read  (dir_read),
  .bus_busy  (bus_busy),
  .start_evt (start_evt),
  .stop_evt  (stop_evt)
);

// File: tb/test_i2c_target_engine.sv
module test_i2c_target_engine;
  localparam int H = 20;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, rx_valid, rx_ready, tx_valid, tx_ready, addressed, dir_read, bus_busy;
  logic [7:0] rx_data, tx_data;
  logic sda_line;
  int checks = 0, errors = 0;
  logic [7:0] exp_rx[$];
  logic [7:0] tx_q[$];
  logic hs_flag = 1'b0;
  logic oe_seen = 1'b0;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_target_engine i_i2c_target_engine (
    .clk, .rst_n, .own_addr(OWN), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe, .rx_data, .rx_valid, .rx_ready, .tx_data, .tx_valid, .tx_ready,
    .addressed, .dir_read, .bus_busy
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor for received bytes (R3, R4, R2)
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_rx.size() == 0) chk("R2/R4 unexpected rx strobe", {24'h0, rx_data}, 32'hDEAD);
      else chk("R3 rx byte", {24'h0, rx_data}, {24'h0, exp_rx.pop_front()});
    end
    if (sda_oe) oe_seen = 1'b1;
  end

  // transmit stream source
  always @(posedge clk) hs_flag <= tx_valid && tx_ready;
  always @(negedge clk) begin
    if (hs_flag && tx_q.size() > 0) void'(tx_q.pop_front());
    tx_valid = (tx_q.size() > 0);
    tx_data  = (tx_q.size() > 0) ? tx_q[0] : 8'h00;
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_n(H); scl_m = 1'b1; wait_n(H);
    sda_m = 1'b0; wait_n(H); scl_m = 1'b0; wait_n(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_n(H); scl_m = 1'b1; wait_n(H);
    sda_m = 1'b1; wait_n(H);
  endtask

  task automatic wbit(input logic b);
    sda_m = b; wait_n(H); scl_m = 1'b1; wait_n(H); scl_m = 1'b0; wait_n(4);
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; wait_n(H); scl_m = 1'b1; wait_n(H/2);
    b = sda_line; wait_n(H/2); scl_m = 1'b0; wait_n(4);
  endtask

  task automatic wbyte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic rbyte(output logic [7:0] v, input logic ack);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      rbit(b);
      v[i] = b;
    end
    wbit(~ack);
  endtask

  // driver: master write of one byte with scoreboard push
  task automatic drv_write(input logic [7:0] v, input logic exp_ack, input string req);
    logic ack;
    if (exp_ack) exp_rx.push_back(v);
    wbyte(v, ack);
    chk(req, {31'h0, ack}, {31'h0, exp_ack});
  endtask

  task automatic drv_read(input logic [7:0] exp_v, input logic ack, input string req);
    logic [7:0] v;
    rbyte(v, ack);
    chk(req, {24'h0, v}, {24'h0, exp_v});
  endtask

  initial begin
    logic ack;
    rx_ready = 1'b1;
    wait_n(5);
    // reset state
    chk("R9 reset sda_oe", {31'h0, sda_oe}, 0);
    chk("R9 reset busy", {31'h0, bus_busy}, 0);
    chk("R10 reset addressed", {31'h0, addressed}, 0);
    chk("R7 reset tx_ready", {31'h0, tx_ready}, 0);
    rst_n = 1'b1;
    wait_n(5);

    // A: write with matching address
    bus_start();
    chk("R8 busy after START", {31'h0, bus_busy}, 1);
    wbyte({OWN, 1'b0}, ack);
    chk("R1 address ACK", {31'h0, ack}, 1);
    chk("R10 addressed after ACK", {31'h0, addressed}, 1);
    chk("R1 direction write", {31'h0, dir_read}, 0);
    drv_write(8'h3C, 1, "R3 ack byte 0x3C");
    drv_write(8'hA5, 1, "R3 ack byte 0xA5");
    bus_stop();
    chk("R9 busy cleared", {31'h0, bus_busy}, 0);
    chk("R9 addressed cleared", {31'h0, addressed}, 0);

    // B: address differing only in LSB
    oe_seen = 1'b0;
    bus_start();
    wbyte({7'h5B, 1'b0}, ack);
    chk("R2 no ACK on mismatch", {31'h0, ack}, 0);
    drv_write(8'h55, 0, "R2 data ignored");
    chk("R2 never drove SDA", {31'h0, oe_seen}, 0);
    chk("R2 not addressed", {31'h0, addressed}, 0);
    chk("R8 busy during foreign transfer", {31'h0, bus_busy}, 1);
    bus_stop();

    // C: user refuses a byte
    bus_start();
    wbyte({OWN, 1'b0}, ack);
    chk("R1 address ACK (C)", {31'h0, ack}, 1);
    rx_ready = 1'b0;
    drv_write(8'hEE, 0, "R4 NACK when not ready");
    rx_ready = 1'b1;
    drv_write(8'h01, 1, "R3 ack after refusal");
    bus_stop();

    // D: read ending in master NACK
    tx_q.push_back(8'h96);
    tx_q.push_back(8'h0F);
    bus_start();
    wbyte({OWN, 1'b1}, ack);
    chk("R1 read address ACK", {31'h0, ack}, 1);
    chk("R1 direction read", {31'h0, dir_read}, 1);
    drv_read(8'h96, 1, "R6 first read byte");
    drv_read(8'h0F, 1, "R6 second read byte");
    drv_read(8'hFF, 0, "R6 empty slot sends 0xFF");
    wait_n(4);
    chk("R7 tx_ready low after NACK", {31'h0, tx_ready}, 0);
    oe_seen = 1'b0;
    tx_q.push_back(8'h00);
    drv_read(8'hFF, 0, "R7 released after NACK");
    chk("R7 no drive after NACK", {31'h0, oe_seen}, 0);
    bus_stop();
    tx_q.delete();

    // E: repeated START changes direction
    bus_start();
    wbyte({OWN, 1'b0}, ack);
    drv_write(8'h11, 1, "R3 write before restart");
    tx_q.push_back(8'h77);
    bus_start();
    chk("R8 addressed cleared by repeated START", {31'h0, addressed}, 0);
    chk("R8 busy held over repeated START", {31'h0, bus_busy}, 1);
    wbyte({OWN, 1'b1}, ack);
    chk("R8 address matched after restart", {31'h0, ack}, 1);
    drv_read(8'h77, 0, "R6 read after restart");
    bus_stop();

    // F: STOP right after an ACK, then re-armed
    bus_start();
    wbyte({OWN, 1'b0}, ack);
    drv_write(8'hC3, 1, "R3 byte before STOP");
    bus_stop();
    chk("R9 sda released at STOP", {31'h0, sda_oe}, 0);
    chk("R9 idle after STOP", {31'h0, bus_busy}, 0);
    bus_start();
    wbyte({OWN, 1'b0}, ack);
    chk("R9 re-armed match", {31'h0, ack}, 1);
    drv_write(8'h42, 1, "R9 write after re-arm");
    bus_stop();

    wait_n(10);
    chk("R3 scoreboard drained", exp_rx.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule